// File: doc/BRIEF.md
# Shared 64-bit Timer with Per-Core Compare

This block holds one free-running 64-bit counter shared by every core, and one 64-bit compare register for each core. Software reaches all of it over a single 32-bit register bus. Each access carries the index of the core that issues it. Every 64-bit quantity is split into a low word and a high word.

The counter is never latched on a read, so the low word can carry into the high word between two accesses. Software gets a consistent 64-bit sample by reading high, then low, then high again, and retrying when the two high words differ.

Each core has its own register window. That window holds:
- a read-only capability word;
- a pending word;
- two interrupt map words;
- a selector for another core;
- the two compare words.

A second window applies the same layout to whichever core the caller's selector names. This lets one core program or inspect the compare state of another.

When the counter equals a core's compare value, that core's compare-pending flag sets. The flag raises the core's timer interrupt once the timer map word is marked valid.

Top module: `core_timer`

## Requirements
- R1: After reset the counter is zero. It then advances by exactly one on every clock, with the carry from bit 31 propagating into the upper word.
- R2: Shared address 0x00 reads and writes counter bits 31:0, and 0x01 reads and writes bits 63:32. A write replaces only the addressed half, and the counter does not advance in the cycle of that write. A read returns the current counter value in the same cycle.
- R3: The counter keeps running between reads. A high–low–high read sequence that spans a low-word wrap returns two different high words. Repeating the sequence afterwards gives a consistent 64-bit value.
- R4: Window offsets are: 0 capability, 1 pending, 2 timer map, 3 performance map, 4 other-core selector, 5 compare low, 6 compare high. The local window sits at 0x10+offset and the other-core window at 0x20+offset. Every compare word resets to all ones and reads back what was written.
- R5: A core's compare-pending flag (pending bit 0) becomes 1 on the clock edge after the counter equals that core's compare value. It then stays 1 while the counter moves on.
- R6: A write to either compare word of a core clears that core's compare-pending flag.
- R7: Pending bit 1 of a core follows that core's performance event input. All other pending bits read 0.
- R8: Map words hold a valid flag in bit 31 and a pin number in the low bits. A core's timer interrupt output equals its compare-pending flag ANDed with its timer map valid flag. Its performance interrupt output equals its event input ANDed with its performance map valid flag.
- R9: Capability bit 0 reports that the timer interrupt can be routed, and bit 1 that the performance interrupt can be routed. By default every core is timer-routable, and only cores 0–2 are performance-routable. A map write to a non-routable source is ignored and its map word reads 0.
- R10: The selector written at local offset 4 chooses the core reached through the other-core window. Other-window reads and writes act on that core's registers. A write to offset 4 through the other-core window has no effect on any selector.
- R11: Reads of unmapped addresses return 0. While no read is requested, the read data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 for write, 0 for read |
| core_i | input | CIDX_W | Index of the core issuing the access |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid in the request cycle |
| perf_evt_i | input | N_CORES | Per-core performance counter event level |
| tmr_irq_o | output | N_CORES | Per-core timer interrupt |
| perf_irq_o | output | N_CORES | Per-core performance interrupt |

## Verification
The hardest situation to reach is a torn counter read, where the low word wraps between the two high-word reads. At the default widths the counter would take billions of cycles to get there on its own. The bench therefore writes the counter to two counts below a low-word wrap and issues the three reads on consecutive cycles, so that the carry lands between them. The compare match is placed in the same way: the bench writes the counter ten counts short of a compare value and watches the interrupt pin on the exact edge where the match must register.

// File: rtl/core_timer_pkg.sv
package core_timer_pkg;
  typedef enum logic [1:0] {
    WIN_SHARED = 2'b00,
    WIN_LOCAL  = 2'b01,
    WIN_OTHER  = 2'b10,
    WIN_NONE   = 2'b11
  } win_e;

  localparam logic [3:0] OFF_CNT_LO = 4'd0;
  localparam logic [3:0] OFF_CNT_HI = 4'd1;

  localparam logic [3:0] OFF_CAP    = 4'd0;
  localparam logic [3:0] OFF_PEND   = 4'd1;
  localparam logic [3:0] OFF_TMAP   = 4'd2;
  localparam logic [3:0] OFF_PMAP   = 4'd3;
  localparam logic [3:0] OFF_OSEL   = 4'd4;
  localparam logic [3:0] OFF_CMP_LO = 4'd5;
  localparam logic [3:0] OFF_CMP_HI = 4'd6;

  localparam int unsigned MAP_VALID_BIT = 31;
endpackage

// File: rtl/core_timer_count.sv
module core_timer_count #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_lo_i,
  input  logic             we_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (we_lo_i) begin
      cnt_q[HALF_W-1:0] <= wdata_i[HALF_W-1:0];
    end else if (we_hi_i) begin
      cnt_q[CNT_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;

  // R1: free running, single step per clock
  p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_lo_i && !we_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: a write holds the untouched half
  p_half_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i |=> (cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W])));
endmodule

// File: rtl/core_timer_slot.sv
module core_timer_slot
  import core_timer_pkg::*;
#(
  parameter int unsigned PIN_W  = 6,
  parameter bit          TMR_OK = 1'b1,
  parameter bit          PERF_OK = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] count_i,
  input  logic        we_i,
  input  logic [3:0]  off_i,
  input  logic [31:0] wdata_i,
  input  logic        perf_evt_i,
  output logic [31:0] rdata_o,
  output logic        tmr_irq_o,
  output logic        perf_irq_o
);
  localparam int unsigned PAD_W = 31 - PIN_W;

  logic [63:0]      cmp_q;
  logic             pend_q;
  logic             tmap_v_q, pmap_v_q;
  logic [PIN_W-1:0] tmap_pin_q, pmap_pin_q;
  logic             cmp_wr;

  assign cmp_wr = we_i && (off_i == OFF_CMP_LO || off_i == OFF_CMP_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      pend_q <= 1'b0;
    end else if (cmp_wr) begin
      if (off_i == OFF_CMP_LO) cmp_q[31:0]  <= wdata_i;
      else                     cmp_q[63:32] <= wdata_i;
      pend_q <= 1'b0;
    end else if (count_i == cmp_q) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmap_v_q   <= 1'b0;
      pmap_v_q   <= 1'b0;
      tmap_pin_q <= '0;
      pmap_pin_q <= '0;
    end else if (we_i) begin
      if (off_i == OFF_TMAP && TMR_OK) begin
        tmap_v_q   <= wdata_i[MAP_VALID_BIT];
        tmap_pin_q <= wdata_i[PIN_W-1:0];
      end
      if (off_i == OFF_PMAP && PERF_OK) begin
        pmap_v_q   <= wdata_i[MAP_VALID_BIT];
        pmap_pin_q <= wdata_i[PIN_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_CAP:    rdata_o = {30'b0, PERF_OK, TMR_OK};
      OFF_PEND:   rdata_o = {30'b0, perf_evt_i, pend_q};
      OFF_TMAP:   rdata_o = {tmap_v_q, {PAD_W{1'b0}}, tmap_pin_q};
      OFF_PMAP:   rdata_o = {pmap_v_q, {PAD_W{1'b0}}, pmap_pin_q};
      OFF_CMP_LO: rdata_o = cmp_q[31:0];
      OFF_CMP_HI: rdata_o = cmp_q[63:32];
      default:    rdata_o = '0;
    endcase
  end

  assign tmr_irq_o  = pend_q & tmap_v_q;
  assign perf_irq_o = perf_evt_i & pmap_v_q;

  // R5: match sets the flag on the following edge
  p_pend_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == cmp_q && !cmp_wr) |=> pend_q);

  // R5: flag is sticky until a compare write
  p_pend_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cmp_wr) |=> pend_q);

  // R6: compare write clears the flag
  p_pend_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr |=> !pend_q);

  // R9: a non-routable source never signals
  p_no_route_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !PERF_OK |-> !perf_irq_o);
endmodule

// File: rtl/core_timer.sv
module core_timer
  import core_timer_pkg::*;
#(
  parameter int unsigned          N_CORES   = 4,
  parameter int unsigned          PIN_W     = 6,
  parameter logic [N_CORES-1:0]   TMR_RTBL  = '1,
  parameter logic [N_CORES-1:0]   PERF_RTBL = 4'b0111,
  localparam int unsigned         CIDX_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [CIDX_W-1:0]  core_i,
  input  logic [5:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [N_CORES-1:0] perf_evt_i,
  output logic [N_CORES-1:0] tmr_irq_o,
  output logic [N_CORES-1:0] perf_irq_o
);
  win_e              win;
  logic [3:0]        off;
  logic [63:0]       count;
  logic [CIDX_W-1:0] osel_q [N_CORES];
  logic [CIDX_W-1:0] own_osel;
  logic [CIDX_W-1:0] tgt;
  logic [31:0]       slot_rd [N_CORES];
  logic [31:0]       tgt_rd;
  logic [N_CORES-1:0] slot_we;
  logic              wr, rd, osel_wr;

  assign win = win_e'(addr_i[5:4]);
  assign off = addr_i[3:0];
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  always_comb begin
    own_osel = '0;
    for (int k = 0; k < N_CORES; k++)
      if (core_i == CIDX_W'(k)) own_osel = osel_q[k];
  end

  assign tgt     = (win == WIN_OTHER) ? own_osel : core_i;
  assign osel_wr = wr && win == WIN_LOCAL && off == OFF_OSEL;

  core_timer_count #(.CNT_W(64)) i_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_lo_i (wr && win == WIN_SHARED && off == OFF_CNT_LO),
    .we_hi_i (wr && win == WIN_SHARED && off == OFF_CNT_HI),
    .wdata_i (wdata_i),
    .count_o (count)
  );

  for (genvar k = 0; k < N_CORES; k++) begin : g_slot
    assign slot_we[k] = wr && (win == WIN_LOCAL || win == WIN_OTHER)
                        && tgt == CIDX_W'(k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             osel_q[k] <= '0;
      else if (osel_wr && core_i == CIDX_W'(k)) osel_q[k] <= wdata_i[CIDX_W-1:0];
    end

    core_timer_slot #(
      .PIN_W   (PIN_W),
      .TMR_OK  (TMR_RTBL[k]),
      .PERF_OK (PERF_RTBL[k])
    ) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .count_i    (count),
      .we_i       (slot_we[k]),
      .off_i      (off),
      .wdata_i    (wdata_i),
      .perf_evt_i (perf_evt_i[k]),
      .rdata_o    (slot_rd[k]),
      .tmr_irq_o  (tmr_irq_o[k]),
      .perf_irq_o (perf_irq_o[k])
    );
  end

  always_comb begin
    tgt_rd = '0;
    for (int k = 0; k < N_CORES; k++)
      if (tgt == CIDX_W'(k)) tgt_rd = slot_rd[k];
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (win)
        WIN_SHARED: begin
          if (off == OFF_CNT_LO)      rdata_o = count[31:0];
          else if (off == OFF_CNT_HI) rdata_o = count[63:32];
        end
        WIN_LOCAL:  rdata_o = (off == OFF_OSEL) ? 32'(own_osel) : tgt_rd;
        WIN_OTHER:  rdata_o = (off == OFF_OSEL) ? '0 : tgt_rd;
        default:    rdata_o = '0;
      endcase
    end
  end

  // R11: idle bus drives zero
  p_rd_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0));

  // R10: selector only moves on a local selector write
  p_osel_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osel_wr |=> (own_osel == $past(own_osel) || core_i != $past(core_i)));
endmodule

// File: tb/test_core_timer.sv
module test_core_timer;
  localparam int N = 4;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h01;
  localparam logic [5:0] L = 6'h10, O = 6'h20;
  localparam logic [5:0] CAP = 0, PEND = 1, TMAP = 2, PMAP = 3, OSEL = 4, CLO = 5, CHI = 6;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [1:0] core = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [N-1:0] perf_evt = 0, tmr_irq, perf_irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  core_timer i_core_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .core_i(core),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .perf_evt_i(perf_evt), .tmr_irq_o(tmr_irq), .perf_irq_o(perf_irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] c, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; core = c; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] c, input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    req = 1; we = 0; core = c; addr = a;
    #1 v = rdata;
    req = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, L + CLO, v); chk("R4 cmp lo reset", v, 32'hFFFF_FFFF);
    rd(3, L + CHI, v); chk("R4 cmp hi reset", v, 32'hFFFF_FFFF);
    rd(0, L + PEND, v); chk("R5 pend reset", v, 0);
    rd(0, A_HI, v); chk("R1 count hi after reset", v, 0);
    chk("R8 irq reset", {60'b0, tmr_irq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(0, A_HI, 0);
    wr(0, A_LO, 32'hFFFF_FFF0);
    rd(0, A_LO, v); chk("R1 step", v, 32'hFFFF_FFF1);
    wr(0, A_LO, 32'hFFFF_FFFF);
    rd(0, A_HI, v); chk("R1 carry", v, 1);
    wr(0, A_HI, 32'h0000_1234);
    wr(0, A_LO, 5);
    rd(0, A_LO, v); chk("R2 lo write no step", v, 6);
    rd(0, A_HI, v); chk("R2 hi kept", v, 32'h1234);
  endtask

  task automatic t_torn();
    logic [31:0] h1, lo, h2;
    wr(0, A_HI, 0);
    wr(0, A_LO, 32'hFFFF_FFFE);
    rd(0, A_HI, h1); rd(0, A_LO, lo); rd(0, A_HI, h2);
    chk("R3 torn hi differ", {h1, h2}, {32'h0, 32'h1});
    rd(0, A_HI, h1); rd(0, A_LO, lo); rd(0, A_HI, h2);
    chk("R3 retry stable", {h1, h2}, {32'h1, 32'h1});
    chk("R3 retry value", {h1, lo}, 64'h1_0000_0003);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(1, L + TMAP, 32'h8000_0002);
    wr(1, L + CHI, 0);
    wr(1, L + CLO, 200);
    rd(1, L + CLO, v); chk("R4 cmp readback", v, 200);
    wr(0, A_HI, 0);
    wr(0, A_LO, 190);
    repeat (10) @(negedge clk);
    chk("R5 not before match", {63'b0, tmr_irq[1]}, 0);
    @(negedge clk);
    chk("R5 set after match", {63'b0, tmr_irq[1]}, 1);
    repeat (20) @(negedge clk);
    rd(1, L + PEND, v); chk("R5 sticky", v, 1);
    wr(1, L + TMAP, 32'h0000_0002);
    chk("R8 map invalid gates", {63'b0, tmr_irq[1]}, 0);
    wr(1, L + TMAP, 32'h8000_0005);
    chk("R8 map valid passes", {63'b0, tmr_irq[1]}, 1);
    rd(1, L + TMAP, v); chk("R8 map readback", v, 32'h8000_0005);
    wr(1, L + CLO, 200);
    chk("R6 cmp write clears", {63'b0, tmr_irq[1]}, 0);
    rd(1, L + PEND, v); chk("R6 pend cleared", v, 0);
  endtask

  task automatic t_perf();
    logic [31:0] v;
    perf_evt[2] = 1;
    rd(2, L + PEND, v); chk("R7 perf bit", v, 2);
    chk("R8 perf gated", {63'b0, perf_irq[2]}, 0);
    wr(2, L + PMAP, 32'h8000_0003);
    chk("R8 perf routed", {63'b0, perf_irq[2]}, 1);
    rd(3, L + CAP, v); chk("R9 cap core3", v, 1);
    rd(0, L + CAP, v); chk("R9 cap core0", v, 3);
    perf_evt[3] = 1;
    wr(3, L + PMAP, 32'h8000_0007);
    chk("R9 non-routable irq", {63'b0, perf_irq[3]}, 0);
    rd(3, L + PMAP, v); chk("R9 non-routable map", v, 0);
  endtask

  task automatic t_other();
    logic [31:0] v;
    wr(0, L + OSEL, 2);
    rd(0, L + OSEL, v); chk("R10 osel readback", v, 2);
    wr(0, O + CLO, 32'h0000_ABCD);
    rd(2, L + CLO, v); chk("R10 other write lands", v, 32'hABCD);
    rd(0, L + CLO, v); chk("R10 own untouched", v, 32'hFFFF_FFFF);
    rd(0, O + PEND, v); chk("R10 other pend read", v, 2);
    wr(0, O + OSEL, 1);
    rd(0, L + OSEL, v); chk("R10 other osel ignored own", v, 2);
    rd(2, L + OSEL, v); chk("R10 other osel ignored tgt", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(0, 6'h3F, v); chk("R11 unmapped high", v, 0);
    rd(0, 6'h08, v); chk("R11 unmapped shared", v, 0);
    @(negedge clk); #1 chk("R11 idle zero", rdata, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_torn();
    t_match();
    t_perf();
    t_other();
    t_unmapped();
    summary();
  end
endmodule